// File: doc/BRIEF.md
# Strobed PCM serial port

This block moves one 8-bit PCM byte per frame in each direction between a codec core and an external line transceiver. An active-high strobe marks the timeslot, and the same slot is used for sending and for receiving. While the strobe is high, the outgoing byte is shifted out most significant bit first, one bit on each rising edge of the bit clock. Over the same slot, incoming bits are captured on falling edges. The serial output carries an enable that drives a three-state pad and is active only inside the slot.

On the parallel side, the port takes the outgoing byte in the cycle the strobe is first seen high and acknowledges it with a pulse. The received byte is delivered with a one-cycle valid pulse as soon as the slot ends, so no frame of delay is added. Muting either direction, or powering down the output driver, replaces the byte with the negative-zero (quiet) code. The quiet code depends on the companding law and on the coding scheme. After each slot the port raises a delayed strobe lasting eight bit periods, so that a second device can take the following timeslot.

Top module: `strobed_pcm_port`

## Requirements
- R1: `sdo_en_o` is high in a bit period exactly when `stb_i` was sampled high at the rising clock edge that starts that period. It is low out of reset.
- R2: At the first rising edge where `stb_i` is sampled high, the port latches the outgoing byte, pulses `tx_take_o` for one cycle and drives bit 7 on `sdo_o`. Each later rising edge of the slot shifts out the next lower bit. Changes to `tx_data_i` during the slot have no effect on the byte being shifted.
- R3: `sdi_i` is captured on the falling edges inside the slot, first bit as bit 7. In the cycle after the strobe is sampled low, `rx_data_o` holds the byte and `rx_valid_o` is high for exactly one cycle.
- R4: A strobe sampled high for other than eight rising edges produces no `rx_valid_o` pulse.
- R5: `dstb_o` rises in the cycle after the strobe is sampled low and stays high for eight bit periods. A later strobe end while it is running restarts the eight periods.
- R6: With `tx_mute_i` high at the slot start, the quiet code is transmitted in place of `tx_data_i`.
- R7: With `drv_pd_i` high at the slot start, the quiet code is transmitted during the slot.
- R8: With `rx_mute_i` high at the slot end, `rx_data_o` carries the quiet code in place of the received byte.
- R9: The quiet code is 8'h00 when `smag_i`=1, whatever the law. Otherwise it is 8'h55 when `law_a_i`=1 (A-law) and 8'h7F when `law_a_i`=0 (mu-law).
- R10: After reset, `sdo_en_o`, `tx_take_o`, `rx_valid_o` and `dstb_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Timeslot strobe, active high |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Drive enable for the three-state output pad |
| tx_data_i | input | 8 | Byte to transmit |
| tx_take_o | output | 1 | Pulse: outgoing byte latched |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Pulse: received byte valid |
| tx_mute_i | input | 1 | Replace the transmitted byte with quiet code |
| rx_mute_i | input | 1 | Replace the received byte with quiet code |
| drv_pd_i | input | 1 | Driver power-down: transmit quiet code |
| law_a_i | input | 1 | 1 = A-law, 0 = mu-law |
| smag_i | input | 1 | 1 = sign-magnitude coding |
| dstb_o | output | 1 | Delayed strobe for a chained device |

## Verification
Two pairs of events can land in the same cycle. First, the end of one slot starts the delayed strobe and delivers the received byte on the same edge. Second, when strobes are separated by a single low bit period, the delayed strobe of the previous slot is still high while the next slot latches its byte and pulses `tx_take_o`. The bench provokes the second case with back-to-back slots. In that cycle it checks `dstb_o`, `tx_take_o` and the first output bit together. It then checks that the delayed strobe restarts for eight periods when the second slot ends.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 2);

  typedef struct packed {
    logic law_a;
    logic smag;
  } coding_t;

  // negative-zero byte for the selected law and coding scheme
  function automatic logic [BYTE_W-1:0] quiet_code(input coding_t c);
    logic [BYTE_W-1:0] q;
    if (c.smag)       q = '0;
    else if (c.law_a) q = 8'h55;
    else              q = 8'h7F;
    return q;
  endfunction
endpackage

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
  import pcm_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  logic              stb_now,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              sdo,
  output logic              sdo_en,
  output logic              take
);
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      sdo_en <= 1'b0;
      take   <= 1'b0;
    end else begin
      sdo_en <= stb_now;
      take   <= slot_start;
      if (slot_start)   shreg <= load_byte;
      else if (stb_now) shreg <= {shreg[BYTE_W-2:0], 1'b0};
    end
  end

  assign sdo = shreg[BYTE_W-1];

  assert_take_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  assert_take_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> sdo_en);
endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
  import pcm_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_active,
  input  logic                 sdi,
  output logic [BYTE_W-1:0]    rx_shreg,
  output logic [BIT_CNT_W-1:0] rx_bits
);
  localparam logic [BIT_CNT_W-1:0] SAT = BIT_CNT_W'(BYTE_W + 1);

  // capture on the falling edge of the bit clock
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_shreg <= '0;
      rx_bits  <= '0;
    end else if (!slot_active) begin
      rx_bits <= '0;
    end else begin
      rx_shreg <= {rx_shreg[BYTE_W-2:0], sdi};
      if (rx_bits != SAT) rx_bits <= rx_bits + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_delay_strobe.sv
module pcm_delay_strobe #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic dstb
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dstb   <= 1'b0;
      remain <= '0;
    end else if (trig) begin
      dstb   <= 1'b1;
      remain <= CW'(LEN - 1);
    end else if (dstb) begin
      if (remain == '0) dstb <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  assert_dstb_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> dstb);
endmodule

// File: rtl/strobed_pcm_port.sv
module strobed_pcm_port
  import pcm_port_pkg::*;
#(
  parameter int DLY_LEN = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              tx_take_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              tx_mute_i,
  input  logic              rx_mute_i,
  input  logic              drv_pd_i,
  input  logic              law_a_i,
  input  logic              smag_i,
  output logic              dstb_o
);
  localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);

  logic                 stb_q;
  logic                 slot_start;
  logic                 slot_end;
  logic                 rx_full;
  coding_t              coding;
  logic [BYTE_W-1:0]    quiet;
  logic [BYTE_W-1:0]    tx_pick;
  logic [BYTE_W-1:0]    rx_shreg;
  logic [BIT_CNT_W-1:0] rx_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_i;
  end

  // named events used by the shifters and the assertions
  assign slot_start = stb_i & ~stb_q;
  assign slot_end   = ~stb_i & stb_q;
  assign rx_full    = (rx_bits == FULL);

  assign coding  = '{law_a: law_a_i, smag: smag_i};
  assign quiet   = quiet_code(coding);
  assign tx_pick = (tx_mute_i | drv_pd_i) ? quiet : tx_data_i;

  pcm_tx_shifter u_tx (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .stb_now(stb_i),
    .load_byte(tx_pick), .sdo(sdo_o), .sdo_en(sdo_en_o), .take(tx_take_o)
  );

  pcm_rx_shifter u_rx (
    .clk(clk), .rst_n(rst_n), .slot_active(stb_q), .sdi(sdi_i),
    .rx_shreg(rx_shreg), .rx_bits(rx_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= slot_end & rx_full;
      if (slot_end & rx_full) rx_data_o <= rx_mute_i ? quiet : rx_shreg;
    end
  end

  pcm_delay_strobe #(.LEN(DLY_LEN)) u_dly (
    .clk(clk), .rst_n(rst_n), .trig(slot_end), .dstb(dstb_o)
  );

  assert_en_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i |=> sdo_en_o);
  assert_en_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> !sdo_en_o);
  assert_valid_after_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (!stb_q && $past(stb_q)));
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  assert_valid_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !rx_full) |=> !rx_valid_o);
endmodule

// File: tb/strobed_pcm_port_test.sv
module strobed_pcm_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en, tx_take, rx_valid, dstb;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic txm = 1'b0, rxm = 1'b0, pd = 1'b0, law = 1'b0, smag = 1'b0;
  int errors = 0, checks = 0;
  logic first_dstb;

  always #2 clk = ~clk;

  strobed_pcm_port uut (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .sdi_i(sdi), .sdo_o(sdo),
    .sdo_en_o(sdo_en), .tx_data_i(tx_data), .tx_take_o(tx_take),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .tx_mute_i(txm),
    .rx_mute_i(rxm), .drv_pd_i(pd), .law_a_i(law), .smag_i(smag),
    .dstb_o(dstb)
  );

  // {tx[20:13], rx[12:5], txm, rxm, pd, law, smag}
  localparam logic [20:0] VEC [6] = '{
    {8'hA5, 8'h3C, 5'b00000},
    {8'h5A, 8'hC3, 5'b10000},
    {8'h12, 8'h81, 5'b01010},
    {8'hFF, 8'h00, 5'b00101},
    {8'h80, 8'h01, 5'b11011},
    {8'h0F, 8'hF0, 5'b00110}
  };

  function automatic logic [7:0] silence(input logic l, input logic s);
    case ({s, l})
      2'b00:   return 8'b0111_1111;
      2'b01:   return 8'b0101_0101;
      default: return 8'b0000_0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one slot of len strobe periods; checks R1 R2 R3 R4 at slot level
  task automatic run_slot(input logic [7:0] txb, input logic [7:0] rxb, input int len,
                          input logic [7:0] exp_tx, input logic [7:0] exp_rx,
                          input logic change_mid);
    logic [7:0] got = '0;
    logic en_ok = 1'b1;
    @(negedge clk);
    stb = 1'b1;
    tx_data = txb;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      if (i == 0) begin
        check("R2 take pulse", tx_take, 1'b1);
        first_dstb = dstb;
      end
      if (i == 1) check("R2 take one cycle", tx_take, 1'b0);
      if (i < 8) got = {got[6:0], sdo};
      if (!sdo_en) en_ok = 1'b0;
      sdi = (i < 8) ? rxb[7-i] : 1'b0;
      if (change_mid && i == 3) tx_data = ~txb;
    end
    @(negedge clk);
    stb = 1'b0;
    @(posedge clk); #1;
    check("R1 enable through slot", en_ok, 1'b1);
    check("R1 enable off after slot", sdo_en, 1'b0);
    if (len == 8) begin
      check("R2 R6 R7 R9 transmitted byte", got, exp_tx);
      check("R3 rx valid", rx_valid, 1'b1);
      check("R3 R8 R9 received byte", rx_data, exp_rx);
    end else begin
      check("R4 no valid for odd strobe", rx_valid, 1'b0);
    end
    check("R5 delayed strobe start", dstb, 1'b1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset en", sdo_en, 1'b0);
    check("R10 reset take", tx_take, 1'b0);
    check("R10 reset valid", rx_valid, 1'b0);
    check("R10 reset dstb", dstb, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] et, er;
      txm = VEC[v][4]; rxm = VEC[v][3]; pd = VEC[v][2];
      law = VEC[v][1]; smag = VEC[v][0];
      et = (txm | pd) ? silence(law, smag) : VEC[v][20:13];
      er = rxm ? silence(law, smag) : VEC[v][12:5];
      run_slot(VEC[v][20:13], VEC[v][12:5], 8, et, er, 1'b0);
      @(posedge clk); #1;
      check("R3 valid one cycle", rx_valid, 1'b0);
      repeat (12) @(posedge clk);
    end
    txm = 0; rxm = 0; pd = 0; law = 0; smag = 0;

    // R5: delayed strobe length
    run_slot(8'h69, 8'h96, 8, 8'h69, 8'h96, 1'b0);
    repeat (7) @(posedge clk);
    #1 check("R5 dstb last period", dstb, 1'b1);
    @(posedge clk); #1 check("R5 dstb ends after eight", dstb, 1'b0);

    // R2: mid-slot change ignored
    run_slot(8'hC6, 8'h5D, 8, 8'hC6, 8'h5D, 1'b1);
    repeat (12) @(posedge clk);

    // R4: short and long strobes
    run_slot(8'h11, 8'h22, 7, 8'h00, 8'h00, 1'b0);
    repeat (12) @(posedge clk);
    run_slot(8'h33, 8'h44, 9, 8'h00, 8'h00, 1'b0);
    repeat (12) @(posedge clk);

    // back-to-back: dstb of previous slot overlaps next slot start
    run_slot(8'hE1, 8'h1E, 8, 8'hE1, 8'h1E, 1'b0);
    run_slot(8'h7E, 8'hB4, 8, 8'h7E, 8'hB4, 1'b0);
    check("R5 dstb overlaps next take", first_dstb, 1'b1);
    repeat (7) @(posedge clk);
    #1 check("R5 dstb restarted", dstb, 1'b1);
    @(posedge clk); #1 check("R5 restarted dstb ends", dstb, 1'b0);

    // R7 with R9 sign-magnitude overriding A-law
    pd = 1; law = 1; smag = 1;
    run_slot(8'hAA, 8'h0C, 8, 8'h00, 8'h0C, 1'b0);
    pd = 0; law = 0; smag = 0;
    repeat (12) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule